// File: doc/BRIEF.md
# Nonvolatile Configuration Download Controller

This block fills a bank of volatile configuration registers from a paged nonvolatile byte store. The store is outside the block and is reached through a synchronous byte port: a read strobe returns data one cycle later, and there are separate write and page-erase strobes. A download copies the low seven pages of the store into the registers. It runs by itself once reset is released. The host can run it again by writing a trigger bit in a control register. A busy flag is high while a download runs, and a one-cycle done pulse marks the end.

The host reaches both spaces through one request port. A single-cycle request carries a 16-bit address, a read/write/erase choice and a data byte. Register addresses go to the register bank. Store addresses are the register addresses with the high byte 0xF8 in front, and they extend through the user pages. A store write first reads the target byte and lands only if that byte is blank. While a download runs, every host request is answered but has no effect.

Top module: `nvcfg_loader`

## Requirements
- R1: From the first cycle after reset is released, busy is high. Store bytes 0x000 to 0xDF are copied in ascending order to register addresses 0x00 to 0xDF, except address 0xD8. The copy ends with busy low and done high exactly 225 cycles after the first cycle out of reset.
- R2: A host write to address 0x00D8 with data bit 0 set, made while not busy, starts the same download. Busy is high from the acknowledging edge for 225 cycles. A read of 0x00D8 while idle returns 0x00, because the trigger bit clears itself at the end.
- R3: Store bytes 0x0E0 to 0x1FF (the reserved page 7 and the user pages 8 to 15) are never downloaded. Register addresses 0xE0 to 0xFF keep the values the host wrote to them.
- R4: While busy, each host request is acknowledged one cycle later with data 0x00 and err low. Writes, erases and store accesses made in that time have no effect.
- R5: A trigger write made during a download neither restarts nor lengthens that download.
- R6: Host addresses 0x0000 to 0x00FF select registers and are acknowledged one cycle after the request. Host addresses 0xF800 to 0xF9FF select store byte addr[8:0] and are acknowledged two cycles after the request. Reads return the addressed byte, and writes return data 0x00.
- R7: A host store write changes the byte only if that byte holds 0xFF. Otherwise err is high with the acknowledge and the byte keeps its value.
- R8: A host erase at a store address sets all 32 bytes of page addr[8:5] to 0xFF.
- R9: A request to any other address, or an erase aimed at a register address, is acknowledged one cycle later with err high and data 0x00, and has no effect.
- R10: done is high for exactly one cycle at the end of each download.
- R11: A write to 0x00D8 with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Single-cycle host request strobe |
| host_wr | input | 1 | Request is a write (when host_erase is low) |
| host_erase | input | 1 | Request is a page erase |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_ack | output | 1 | Request completed (one-cycle pulse) |
| host_rdata | output | 8 | Read data, valid with host_ack |
| host_err | output | 1 | Request rejected, valid with host_ack |
| busy | output | 1 | Download in progress |
| done | output | 1 | One-cycle pulse at download end |
| nv_rd_en | output | 1 | Store read strobe |
| nv_wr_en | output | 1 | Store byte write strobe |
| nv_erase_en | output | 1 | Store page erase strobe |
| nv_addr | output | 9 | Store byte index |
| nv_wdata | output | 8 | Store write data |
| nv_rdata | input | 8 | Store read data, one cycle after nv_rd_en |

## Verification
The hardest case to reach is a host request that arrives during a download. This covers both a second trigger, which must leave the end cycle unchanged, and a store erase or register write, which must leave no mark. The stimulus issues such requests in the cycles right after reset is released and again in the middle of a host-triggered download. The effects are read back only after the download ends. Blank-check rejection depends on store contents that a download has just copied into the registers. The bench therefore erases page 0, writes new bytes there, retriggers the download, and reads the registers to confirm that the erased and rewritten values arrived.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

    localparam int BYTE_W     = 8;
    localparam int HADDR_W    = 16;
    localparam int PAGE_BYTES = 32;
    localparam int NV_PAGES   = 16;
    localparam int DL_PAGES   = 7;
    localparam int REG_AW     = 8;

    localparam int NV_BYTES   = PAGE_BYTES * NV_PAGES;
    localparam int NV_IDX_W   = $clog2(NV_BYTES);
    localparam int PG_OFS_W   = $clog2(PAGE_BYTES);
    localparam int REG_COUNT  = 1 << REG_AW;
    localparam int DL_BYTES   = PAGE_BYTES * DL_PAGES;

    localparam logic [BYTE_W-1:0]  NV_PREFIX = 8'hF8;
    localparam logic [HADDR_W-1:0] NV_BASE   = {NV_PREFIX, {REG_AW{1'b0}}};
    localparam logic [REG_AW-1:0]  CTRL_ADDR = 8'hD8;
    localparam logic [BYTE_W-1:0]  BLANK     = 8'hFF;

    typedef enum logic [1:0] {OP_RD, OP_WR, OP_ER} op_e;
    typedef enum logic [1:0] {SP_REG, SP_NV, SP_NONE} space_e;

    typedef struct packed {
        op_e                 op;
        logic [NV_IDX_W-1:0] idx;
        logic [BYTE_W-1:0]   data;
    } nv_req_t;

    function automatic space_e addr_space(input logic [HADDR_W-1:0] a);
        if (a[HADDR_W-1:REG_AW] == '0)
            return SP_REG;
        else if (int'(a) >= int'(NV_BASE) && int'(a) < int'(NV_BASE) + NV_BYTES)
            return SP_NV;
        else
            return SP_NONE;
    endfunction

    function automatic logic [NV_IDX_W-1:0] nv_index(input logic [HADDR_W-1:0] a);
        logic [HADDR_W-1:0] ofs;
        ofs = a - NV_BASE;
        return ofs[NV_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/nvl_reg_bank.sv
module nvl_reg_bank
    import nvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] regs [REG_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
        end else if (we && waddr != CTRL_ADDR) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];

endmodule

// File: rtl/nvl_dl_seq.sv
module nvl_dl_seq
    import nvl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic                rd_en,
    output logic [NV_IDX_W-1:0] rd_idx,
    output logic                wr_en,
    output logic [REG_AW-1:0]   wr_addr
);

    localparam logic [NV_IDX_W-1:0] LAST_IDX = NV_IDX_W'(DL_BYTES - 1);

    logic [NV_IDX_W-1:0] idx_q;
    logic                pend_q;

    assign rd_en   = busy && (idx_q < NV_IDX_W'(DL_BYTES));
    assign rd_idx  = idx_q;
    assign wr_en   = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            wr_addr <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    idx_q  <= '0;
                    pend_q <= 1'b0;
                end
            end else begin
                pend_q  <= rd_en;
                wr_addr <= idx_q[REG_AW-1:0];
                if (rd_en) idx_q <= idx_q + 1'b1;
                if (pend_q && {1'b0, wr_addr} == LAST_IDX) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/nvl_host_if.sv
module nvl_host_if
    import nvl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                busy,
    input  logic                host_valid,
    input  logic                host_wr,
    input  logic                host_erase,
    input  logic [HADDR_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic                host_ack,
    output logic [BYTE_W-1:0]   host_rdata,
    output logic                host_err,
    output logic                start,
    output logic                reg_we,
    output logic [REG_AW-1:0]   reg_addr,
    output logic [BYTE_W-1:0]   reg_wdata,
    input  logic [BYTE_W-1:0]   reg_rdata,
    output logic                nv_rd_en,
    output logic                nv_wr_en,
    output logic                nv_erase_en,
    output logic [NV_IDX_W-1:0] nv_addr,
    output logic [BYTE_W-1:0]   nv_wdata,
    input  logic [BYTE_W-1:0]   nv_rdata
);

    typedef enum logic {H_IDLE, H_NV} hstate_e;

    hstate_e state;
    nv_req_t pend;
    op_e     op_in;
    space_e  sp;
    logic    accept;

    always_comb begin
        op_in       = host_erase ? OP_ER : (host_wr ? OP_WR : OP_RD);
        sp          = addr_space(host_addr);
        accept      = (state == H_IDLE) && host_valid && !busy;
        reg_addr    = host_addr[REG_AW-1:0];
        reg_wdata   = host_wdata;
        reg_we      = accept && sp == SP_REG && op_in == OP_WR && reg_addr != CTRL_ADDR;
        start       = accept && sp == SP_REG && op_in == OP_WR && reg_addr == CTRL_ADDR
                      && host_wdata[0];
        nv_rd_en    = accept && sp == SP_NV && op_in != OP_ER;
        nv_addr     = (state == H_NV) ? pend.idx : nv_index(host_addr);
        nv_wdata    = pend.data;
        nv_wr_en    = (state == H_NV) && pend.op == OP_WR && nv_rdata == BLANK;
        nv_erase_en = (state == H_NV) && pend.op == OP_ER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= H_IDLE;
            pend       <= '0;
            host_ack   <= 1'b0;
            host_err   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= 1'b0;
            host_err <= 1'b0;
            if (state == H_NV) begin
                state      <= H_IDLE;
                host_ack   <= 1'b1;
                host_rdata <= (pend.op == OP_RD) ? nv_rdata : '0;
                host_err   <= (pend.op == OP_WR) && (nv_rdata != BLANK);
            end else if (host_valid) begin
                if (busy) begin
                    host_ack   <= 1'b1;
                    host_rdata <= '0;
                end else if (sp == SP_NV) begin
                    state <= H_NV;
                    pend  <= '{op: op_in, idx: nv_index(host_addr), data: host_wdata};
                end else if (sp == SP_REG && op_in != OP_ER) begin
                    host_ack   <= 1'b1;
                    host_rdata <= (op_in == OP_WR) ? '0 :
                                  (reg_addr == CTRL_ADDR) ? {{(BYTE_W-1){1'b0}}, busy} :
                                  reg_rdata;
                end else begin
                    host_ack   <= 1'b1;
                    host_err   <= 1'b1;
                    host_rdata <= '0;
                end
            end
        end
    end

    // R7
    blank_read_first_chk: assert property (@(posedge clk) disable iff (rst)
        nv_wr_en |-> ($past(nv_rd_en) && $past(nv_addr) == nv_addr));

    // R6
    nv_ack_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (state == H_NV) |=> host_ack);

endmodule

// File: rtl/nvcfg_loader.sv
module nvcfg_loader
    import nvl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_valid,
    input  logic                host_wr,
    input  logic                host_erase,
    input  logic [15:0]         host_addr,
    input  logic [7:0]          host_wdata,
    output logic                host_ack,
    output logic [7:0]          host_rdata,
    output logic                host_err,
    output logic                busy,
    output logic                done,
    output logic                nv_rd_en,
    output logic                nv_wr_en,
    output logic                nv_erase_en,
    output logic [8:0]          nv_addr,
    output logic [7:0]          nv_wdata,
    input  logic [7:0]          nv_rdata
);

    logic                dl_rd_en, dl_wr_en, start;
    logic [NV_IDX_W-1:0] dl_rd_idx, h_nv_addr;
    logic [REG_AW-1:0]   dl_wr_addr, h_reg_addr;
    logic                h_reg_we, h_nv_rd_en;
    logic [BYTE_W-1:0]   h_reg_wdata, reg_rdata;

    nvl_dl_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .rd_en(dl_rd_en), .rd_idx(dl_rd_idx), .wr_en(dl_wr_en), .wr_addr(dl_wr_addr)
    );

    nvl_host_if u_host (
        .clk(clk), .rst(rst), .busy(busy),
        .host_valid(host_valid), .host_wr(host_wr), .host_erase(host_erase),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_err(host_err),
        .start(start), .reg_we(h_reg_we), .reg_addr(h_reg_addr),
        .reg_wdata(h_reg_wdata), .reg_rdata(reg_rdata),
        .nv_rd_en(h_nv_rd_en), .nv_wr_en(nv_wr_en), .nv_erase_en(nv_erase_en),
        .nv_addr(h_nv_addr), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata)
    );

    nvl_reg_bank u_bank (
        .clk(clk), .rst(rst),
        .we(dl_wr_en | h_reg_we),
        .waddr(dl_wr_en ? dl_wr_addr : h_reg_addr),
        .wdata(dl_wr_en ? nv_rdata : h_reg_wdata),
        .raddr(h_reg_addr),
        .rdata(reg_rdata)
    );

    assign nv_rd_en = dl_rd_en | h_nv_rd_en;
    assign nv_addr  = busy ? dl_rd_idx : h_nv_addr;

    // R4
    no_store_change_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!nv_wr_en && !nv_erase_en));

    // R3
    dl_page_range_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && nv_rd_en) |-> (nv_addr < NV_IDX_W'(DL_BYTES)));

endmodule

// File: tb/sim_nvcfg_loader.sv
module sim_nvcfg_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0, host_wr = 1'b0, host_erase = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack, host_err, busy, done;
    logic [7:0]  host_rdata;
    logic        nv_rd_en, nv_wr_en, nv_erase_en;
    logic [8:0]  nv_addr;
    logic [7:0]  nv_wdata;
    logic [7:0]  nv_rdata = '0;

    always #10 clk = ~clk;

    nvcfg_loader u0 (.*);

    // external store
    logic [7:0] nv_mem [512];
    always @(posedge clk) begin
        if (nv_erase_en) for (int k = 0; k < 32; k++) nv_mem[{nv_addr[8:5], 5'(k)}] <= 8'hFF;
        if (nv_wr_en) nv_mem[nv_addr] <= nv_wdata;
        if (nv_rd_en) nv_rdata <= nv_mem[nv_addr];
    end

    // reference model
    typedef struct {int due; logic [7:0] rd; logic er;} resp_t;
    resp_t       q[$];
    logic [7:0]  m_nv  [512];
    logic [7:0]  m_ram [256];
    int          cyc = 0, m_left = 0;
    bit          m_busy = 1'b1;
    bit          e_ack = 0, e_err = 0, e_done = 0;
    logic [7:0]  e_rdata = 0;

    always @(posedge clk) begin
        bit    b0;
        resp_t r;
        int    a;
        cyc++;
        e_ack = 0; e_err = 0; e_done = 0;
        if (rst) begin
            m_busy = 1; m_left = 225; q.delete();
            for (int k = 0; k < 256; k++) m_ram[k] = 8'h00;
        end else begin
            b0 = m_busy;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    for (int k = 0; k < 224; k++) if (k != 'hD8) m_ram[k] = m_nv[k];
                    m_busy = 0; e_done = 1;
                end
            end
            if (host_valid) begin
                a = int'(host_addr);
                r.due = cyc; r.rd = 0; r.er = 0;
                if (b0) begin
                end else if (a < 256) begin
                    if (host_erase) r.er = 1;
                    else if (host_wr) begin
                        if (a == 'hD8) begin
                            if (host_wdata[0]) begin m_busy = 1; m_left = 225; end
                        end else m_ram[a] = host_wdata;
                    end else r.rd = (a == 'hD8) ? 8'h00 : m_ram[a];
                end else if (a >= 'hF800 && a < 'hFA00) begin
                    a = a - 'hF800;
                    r.due = cyc + 1;
                    if (host_erase) for (int k = 0; k < 32; k++) m_nv[(a / 32) * 32 + k] = 8'hFF;
                    else if (host_wr) begin
                        if (m_nv[a] == 8'hFF) m_nv[a] = host_wdata; else r.er = 1;
                    end else r.rd = m_nv[a];
                end else r.er = 1;
                q.push_back(r);
            end
            if (q.size() > 0 && q[0].due == cyc) begin
                r = q.pop_front();
                e_ack = 1; e_rdata = r.rd; e_err = r.er;
            end
        end
    end

    // checking
    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    ended = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 0 && !ended) begin
            check(busy === m_busy, "busy", int'(busy), int'(m_busy));
            check(done === e_done, "done", int'(done), int'(e_done));
            check(host_ack === e_ack, "ack", int'(host_ack), int'(e_ack));
            if (e_ack) begin
                check(host_rdata === e_rdata, "rdata", int'(host_rdata), int'(e_rdata));
                check(host_err === e_err, "err", int'(host_err), int'(e_err));
            end
        end
    end

    task automatic finish_run();
        ended = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    // kind: 0 read, 1 write, 2 erase
    task automatic host_op(input int kind, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_valid = 1; host_wr = (kind == 1); host_erase = (kind == 2);
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 0; host_wr = 0; host_erase = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            nv_mem[i] = (i < 224) ? 8'((i * 13 + 5) & 8'h7F) : 8'hFF;
            m_nv[i] = nv_mem[i];
        end
        nv_mem['h1F0] = 8'h42; m_nv['h1F0] = 8'h42;
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R4";
        host_op(0, 16'h0005, 8'h00);
        host_op(1, 16'h0020, 8'h55);
        host_op(2, 16'hF800, 8'h00);
        host_op(1, 16'hF9F1, 8'h11);
        cur_req = "R5";
        host_op(1, 16'h00D8, 8'h01);
        cur_req = "R1";
        wait_idle();
        host_op(0, 16'h0005, 8'h00);
        host_op(0, 16'h0020, 8'h00);
        host_op(0, 16'h00DF, 8'h00);
        cur_req = "R3";
        host_op(0, 16'h00E0, 8'h00);
        host_op(1, 16'h00E0, 8'h77);
        host_op(1, 16'hF8E5, 8'h99);
        cur_req = "R6";
        host_op(1, 16'h0010, 8'hA5);
        host_op(0, 16'h0010, 8'h00);
        host_op(0, 16'hF810, 8'h00);
        host_op(0, 16'hF9F1, 8'h00);
        cur_req = "R7";
        host_op(1, 16'hF810, 8'h3C);
        host_op(1, 16'hF9F0, 8'h01);
        host_op(1, 16'hF900, 8'h5A);
        host_op(0, 16'hF900, 8'h00);
        host_op(1, 16'hF900, 8'h6B);
        cur_req = "R8";
        host_op(2, 16'hF81F, 8'h00);
        host_op(0, 16'hF805, 8'h00);
        host_op(1, 16'hF810, 8'h3C);
        host_op(0, 16'hF810, 8'h00);
        cur_req = "R9";
        host_op(0, 16'h1234, 8'h00);
        host_op(1, 16'hFA00, 8'h12);
        host_op(2, 16'h0030, 8'h00);
        host_op(0, 16'h0030, 8'h00);
        cur_req = "R11";
        host_op(1, 16'h00D8, 8'hFE);
        host_op(0, 16'h00D8, 8'h00);
        cur_req = "R2";
        host_op(1, 16'h00D8, 8'h01);
        repeat (60) @(negedge clk);
        cur_req = "R5";
        host_op(1, 16'h00D8, 8'h01);
        host_op(1, 16'h0011, 8'h22);
        cur_req = "R10";
        wait_idle();
        cur_req = "R2";
        host_op(0, 16'h00D8, 8'h00);
        host_op(0, 16'h0010, 8'h00);
        host_op(0, 16'h0011, 8'h00);
        host_op(0, 16'h0005, 8'h00);
        cur_req = "R3";
        host_op(0, 16'h00E0, 8'h00);
        host_op(0, 16'h00E5, 8'h00);
        host_op(0, 16'hF8E5, 8'h00);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule